// File: doc/BRIEF.md
# Packet Radio Link Controller

This block is the top-level controller that sits between a user data path and a packet radio chip reached through a separate SPI sequencer. After reset it wakes the radio: it starts the crystal oscillator, writes three configuration registers and switches the receiver on. It then takes 32-bit words from a valid/ready stream, copies each word into the radio's transmit buffer and fires the transmit strobe, but only when the radio's clear-channel pin is high. When the channel is busy it waits a pseudo-random number of symbol periods. During that wait it keeps draining the radio's receive buffer onto a 32-bit output stream.

Every command goes to the sequencer as one record: a header byte, a payload byte count and up to four payload bytes. In the header, bit 7 is always 0, bit 6 is 1 for a read, and bits 5:0 hold the radio register address. The sequencer takes the record with `cmd_ready` and reports completion with `seq_done`, which also returns read data. After any receive-on strobe, and after the radio's frame-delimiter pin falls at the end of a transmission, the controller waits 12 symbol periods before it sends another transmit strobe. A request on `chan_req` retunes the radio at run time without a reset.

Both streams follow the same back-pressure rule. A source that raises valid keeps it high and keeps its data unchanged until the cycle in which ready is also high. The word moves in that cycle. `tx_ready` stays low from the moment a word is accepted until that word's transmit strobe has completed, and it also stays low while the radio is still sending.

Top module: `radio_ctl`

## Requirements
- R1: After reset the controller issues exactly these five commands, in this order, with `tx_ready` low throughout: strobe 0x01 (header 0x01, 0 bytes); write 0x11 with the configured value and bit 11 forced to 0 (header 0x11, 2 bytes); write 0x1C with the FIFOP threshold in bits 6:0, default 64 (header 0x1C, 2 bytes); write 0x18 with `chan_code` in bits 9:0 (header 0x18, 2 bytes); strobe 0x03 (header 0x03, 0 bytes).
- R2: Every header has bit 7 = 0 and bit 6 = 1 only for reads. The only read is the receive-buffer read: header 0x7F with 4 payload bytes.
- R3: An accepted transmit word is written to the transmit buffer as header 0x3E with 4 bytes carrying the word. `tx_ready` is low from acceptance until the transmit strobe has completed.
- R4: The transmit strobe (header 0x04, 0 bytes) is issued only while `rf_cca` is high. While `rf_cca` stays low, no transmit strobe is issued.
- R5: At least 12 symbol periods (12 × CYC_PER_SYM cycles) separate completion of a receive-on strobe from the next transmit strobe.
- R6: When the channel is busy, the controller waits (LFSR & `bo_mask`) + 1 symbol periods before it samples `rf_cca` again. A transmit strobe therefore follows a rise of `rf_cca` within (`bo_mask` + 1) symbol periods plus a few cycles.
- R7: While waiting on a busy channel, `rf_fifop` and `rf_fifo` both high cause a receive-buffer read. The returned 32 bits appear on `rx_word` with `rx_valid`, held stable until `rx_ready`.
- R8: `rf_fifop` high with `rf_fifo` low (overflow) causes a flush strobe (header 0x08, 0 bytes).
- R9: A pulse on `chan_req` causes strobe 0x06, then a write of header 0x18 with the new `chan_code` in bits 9:0, then strobe 0x03, all without reset.
- R10: After a transmit strobe, `tx_ready` stays low while `rf_sfd` is high and returns once `rf_sfd` falls.
- R11: `cmd_valid`, once raised, stays high with header, count and data stable until `cmd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Controller can take a transmit word |
| tx_word | input | 32 | Transmit word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes received word |
| rx_word | output | 32 | Received word |
| chan_req | input | 1 | Pulse: retune to `chan_code` |
| chan_code | input | 10 | Frequency field value (bits 9:0 of register 0x18) |
| bo_mask | input | 8 | Mask on the backoff symbol count |
| rf_fifo | input | 1 | Radio: receive buffer not empty |
| rf_fifop | input | 1 | Radio: receive threshold reached |
| rf_cca | input | 1 | Radio: channel clear |
| rf_sfd | input | 1 | Radio: frame delimiter active |
| cmd_valid | output | 1 | Command record offered to sequencer |
| cmd_ready | input | 1 | Sequencer takes the record |
| cmd_head | output | 8 | Header byte {0, read, address} |
| cmd_nbytes | output | 3 | Payload bytes after the header |
| cmd_data | output | 32 | Payload, low bytes used for 2-byte writes |
| seq_done | input | 1 | Sequencer finished the record |
| seq_rdata | input | 32 | Read data returned with `seq_done` |

## Verification
The transmit path runs under three channel patterns. With the channel clear the whole time, the bench checks buffer load, strobe order and settle timing. With the channel held busy, it confirms that no strobe appears and that receive service happens in the wait. With the channel busy and then released, the strobe latency stays inside the masked backoff bound. Holding `rx_ready` low during a read separates a correct hold of the output word from a dropped or overwritten one. An overflow pattern (threshold pin without the not-empty pin) and a run-time retune, each followed by another transmission, show that the flush and the channel sequence leave the settle rule intact.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam logic [5:0] A_XOSC    = 6'h01;
  localparam logic [5:0] A_RXON    = 6'h03;
  localparam logic [5:0] A_TXON    = 6'h04;
  localparam logic [5:0] A_RFOFF   = 6'h06;
  localparam logic [5:0] A_FLUSHRX = 6'h08;
  localparam logic [5:0] A_MDM     = 6'h11;
  localparam logic [5:0] A_FREQ    = 6'h18;
  localparam logic [5:0] A_IOCFG   = 6'h1C;
  localparam logic [5:0] A_TXBUF   = 6'h3E;
  localparam logic [5:0] A_RXBUF   = 6'h3F;

  typedef enum logic [3:0] {
    S_INIT, S_READY, S_CCA_CHK, S_BACKOFF, S_TX_LOAD,
    S_TX_SEND, S_RX, S_FLUSH, S_CHAN
  } ctl_state_t;

  typedef struct packed {
    logic [7:0]  head;
    logic [2:0]  nbytes;
    logic [31:0] data;
  } spi_cmd_t;

  function automatic logic [7:0] mk_head(input logic rd, input logic [5:0] a);
    return {1'b0, rd, a};
  endfunction
endpackage

// File: rtl/rc_lfsr.sv
module rc_lfsr #(
  parameter int          SW   = 16,
  parameter int          OW   = 8,
  parameter logic [15:0] TAPS = 16'hB400,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [OW-1:0] q
);
  logic [SW-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n) sr <= SEED[SW-1:0];
    else if (sr[0]) sr <= (sr >> 1) ^ TAPS[SW-1:0];
    else sr <= sr >> 1;
  end

  assign q = sr[OW-1:0];
endmodule

// File: rtl/rc_symtimer.sv
module rc_symtimer #(
  parameter int CPS = 1600,
  parameter int NW  = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] nsym,
  output logic          busy
);
  localparam int CW = (CPS > 1) ? $clog2(CPS) : 1;

  logic [NW-1:0] sym_left;
  logic [CW-1:0] tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym_left <= '0;
      tick     <= '0;
    end else if (start) begin
      sym_left <= nsym;
      tick     <= '0;
    end else if (sym_left != '0) begin
      if (tick == CW'(CPS - 1)) begin
        tick     <= '0;
        sym_left <= sym_left - 1'b1;
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end

  assign busy = (sym_left != '0);
endmodule

// File: rtl/rc_cmd_issue.sv
module rc_cmd_issue
  import rc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  spi_cmd_t    cmd_in,
  output logic        idle,
  output logic        fin,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [7:0]  cmd_head,
  output logic [2:0]  cmd_nbytes,
  output logic [31:0] cmd_data,
  input  logic        seq_done
);
  typedef enum logic [1:0] {I_IDLE, I_OFFER, I_WAIT} iss_t;

  iss_t     ist;
  spi_cmd_t held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ist  <= I_IDLE;
      held <= '0;
    end else begin
      case (ist)
        I_IDLE:  if (go) begin
                   held <= cmd_in;
                   ist  <= I_OFFER;
                 end
        I_OFFER: if (cmd_ready) ist <= I_WAIT;
        I_WAIT:  if (seq_done) ist <= I_IDLE;
        default: ist <= I_IDLE;
      endcase
    end
  end

  assign idle       = (ist == I_IDLE);
  assign fin        = (ist == I_WAIT) && seq_done;
  assign cmd_valid  = (ist == I_OFFER);
  assign cmd_head   = held.head;
  assign cmd_nbytes = held.nbytes;
  assign cmd_data   = held.data;
endmodule

// File: rtl/radio_ctl.sv
module radio_ctl
  import rc_pkg::*;
#(
  parameter int          CYC_PER_SYM = 1600,
  parameter int          SETTLE_SYM  = 12,
  parameter int          BO_W        = 8,
  parameter logic [15:0] MDM_INIT    = 16'h0AE2,
  parameter logic [6:0]  FIFOP_THR   = 7'd64,
  parameter logic [8:0]  IOCFG_HI    = 9'd0,
  parameter logic [5:0]  FS_HI       = 6'h10,
  parameter logic [15:0] LFSR_SEED   = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_valid,
  output logic        tx_ready,
  input  logic [31:0] tx_word,
  output logic        rx_valid,
  input  logic        rx_ready,
  output logic [31:0] rx_word,
  input  logic        chan_req,
  input  logic [9:0]  chan_code,
  input  logic [7:0]  bo_mask,
  input  logic        rf_fifo,
  input  logic        rf_fifop,
  input  logic        rf_cca,
  input  logic        rf_sfd,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [7:0]  cmd_head,
  output logic [2:0]  cmd_nbytes,
  output logic [31:0] cmd_data,
  input  logic        seq_done,
  input  logic [31:0] seq_rdata
);
  localparam int SW_SET = $clog2(SETTLE_SYM + 1);
  localparam int NW     = (SW_SET > BO_W + 1) ? SW_SET : BO_W + 1;
  localparam logic [2:0] INIT_LAST = 3'd4;
  localparam logic [2:0] CHAN_LAST = 3'd2;

  ctl_state_t st, rx_ret;
  logic [2:0]  step;
  spi_cmd_t    cur;
  logic        need_cmd, iss_idle, fin, go;
  logic        settle_busy, bo_busy, settle_start, bo_start;
  logic [NW-1:0]   bo_nsym;
  logic [BO_W-1:0] rnd;
  logic        sfd_q, tx_busy, chan_pend, rx_hold;
  logic [9:0]  chan_val;
  logic [31:0] tx_buf, rx_q;
  logic        ovf, rx_avail, tx_done, rxon_fin;

  assign ovf      = rf_fifop && !rf_fifo;
  assign rx_avail = rf_fifop && rf_fifo;
  assign tx_done  = tx_busy && sfd_q && !rf_sfd;

  // command selected by the current state and step
  always_comb begin
    cur      = '0;
    need_cmd = 1'b0;
    case (st)
      S_INIT: begin
        need_cmd = 1'b1;
        case (step)
          3'd0: cur.head = mk_head(1'b0, A_XOSC);
          3'd1: begin
            cur.head   = mk_head(1'b0, A_MDM);
            cur.nbytes = 3'd2;
            cur.data   = {16'h0, MDM_INIT & ~16'h0800};
          end
          3'd2: begin
            cur.head   = mk_head(1'b0, A_IOCFG);
            cur.nbytes = 3'd2;
            cur.data   = {16'h0, IOCFG_HI, FIFOP_THR};
          end
          3'd3: begin
            cur.head   = mk_head(1'b0, A_FREQ);
            cur.nbytes = 3'd2;
            cur.data   = {16'h0, FS_HI, chan_val};
          end
          default: cur.head = mk_head(1'b0, A_RXON);
        endcase
      end
      S_CHAN: begin
        need_cmd = 1'b1;
        case (step)
          3'd0: cur.head = mk_head(1'b0, A_RFOFF);
          3'd1: begin
            cur.head   = mk_head(1'b0, A_FREQ);
            cur.nbytes = 3'd2;
            cur.data   = {16'h0, FS_HI, chan_val};
          end
          default: cur.head = mk_head(1'b0, A_RXON);
        endcase
      end
      S_FLUSH: begin
        need_cmd = 1'b1;
        cur.head = mk_head(1'b0, A_FLUSHRX);
      end
      S_TX_LOAD: begin
        need_cmd   = 1'b1;
        cur.head   = mk_head(1'b0, A_TXBUF);
        cur.nbytes = 3'd4;
        cur.data   = tx_buf;
      end
      S_TX_SEND: begin
        need_cmd = 1'b1;
        cur.head = mk_head(1'b0, A_TXON);
      end
      S_RX: begin
        need_cmd   = !rx_hold;
        cur.head   = mk_head(1'b1, A_RXBUF);
        cur.nbytes = 3'd4;
      end
      default: ;
    endcase
  end

  assign go = need_cmd && iss_idle;

  rc_cmd_issue u_iss (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .cmd_in     (cur),
    .idle       (iss_idle),
    .fin        (fin),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_head   (cmd_head),
    .cmd_nbytes (cmd_nbytes),
    .cmd_data   (cmd_data),
    .seq_done   (seq_done)
  );

  rc_lfsr #(.SW(16), .OW(BO_W), .SEED(LFSR_SEED)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .q     (rnd)
  );

  assign rxon_fin = fin && (((st == S_INIT) && (step == INIT_LAST)) ||
                            ((st == S_CHAN) && (step == CHAN_LAST)));
  assign settle_start = rxon_fin || tx_done;
  assign bo_start     = (st == S_CCA_CHK) && !settle_busy && !rf_cca;
  assign bo_nsym      = NW'(rnd & bo_mask) + NW'(1);

  rc_symtimer #(.CPS(CYC_PER_SYM), .NW(NW)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .start (settle_start),
    .nsym  (NW'(SETTLE_SYM)),
    .busy  (settle_busy)
  );

  rc_symtimer #(.CPS(CYC_PER_SYM), .NW(NW)) u_backoff (
    .clk   (clk),
    .rst_n (rst_n),
    .start (bo_start),
    .nsym  (bo_nsym),
    .busy  (bo_busy)
  );

  assign tx_ready = (st == S_READY) && !ovf && !chan_pend && !rx_avail && !tx_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_INIT;
      rx_ret    <= S_READY;
      step      <= '0;
      sfd_q     <= 1'b0;
      tx_busy   <= 1'b0;
      chan_pend <= 1'b0;
      chan_val  <= '0;
      tx_buf    <= '0;
      rx_hold   <= 1'b0;
      rx_q      <= '0;
    end else begin
      sfd_q <= rf_sfd;
      if (tx_done) tx_busy <= 1'b0;
      if (st == S_INIT && step < 3'd3) chan_val <= chan_code;

      case (st)
        S_INIT: if (fin) begin
          if (step == INIT_LAST) begin
            st   <= S_READY;
            step <= '0;
          end else begin
            step <= step + 1'b1;
          end
        end
        S_READY: begin
          if (ovf) begin
            st     <= S_FLUSH;
            rx_ret <= S_READY;
          end else if (chan_pend) begin
            st   <= S_CHAN;
            step <= '0;
          end else if (rx_avail) begin
            st     <= S_RX;
            rx_ret <= S_READY;
          end else if (tx_valid && tx_ready) begin
            tx_buf <= tx_word;
            st     <= S_TX_LOAD;
          end
        end
        S_CHAN: if (fin) begin
          if (step == CHAN_LAST) begin
            st        <= S_READY;
            step      <= '0;
            chan_pend <= 1'b0;
          end else begin
            step <= step + 1'b1;
          end
        end
        S_FLUSH:   if (fin) st <= rx_ret;
        S_TX_LOAD: if (fin) st <= S_CCA_CHK;
        S_CCA_CHK: if (!settle_busy) st <= rf_cca ? S_TX_SEND : S_BACKOFF;
        S_BACKOFF: begin
          if (ovf) begin
            st     <= S_FLUSH;
            rx_ret <= S_CCA_CHK;
          end else if (rx_avail) begin
            st     <= S_RX;
            rx_ret <= S_CCA_CHK;
          end else if (!bo_busy) begin
            st <= S_CCA_CHK;
          end
        end
        S_TX_SEND: if (fin) begin
          st      <= S_READY;
          tx_busy <= 1'b1;
        end
        S_RX: begin
          if (fin) begin
            rx_hold <= 1'b1;
            rx_q    <= seq_rdata;
          end
          if (rx_hold && rx_ready) begin
            rx_hold <= 1'b0;
            st      <= rx_ret;
          end
        end
        default: st <= S_READY;
      endcase

      if (chan_req) begin
        chan_pend <= 1'b1;
        chan_val  <= chan_code;
      end
    end
  end

  assign rx_valid = rx_hold;
  assign rx_word  = rx_q;
endmodule

// File: rtl/rc_chk.sv
module rc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_ready,
  input logic        rx_valid,
  input logic        rx_ready,
  input logic [31:0] rx_word,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [7:0]  cmd_head,
  input logic [2:0]  cmd_nbytes,
  input logic [31:0] cmd_data
);
  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_head) &&
                                $stable(cmd_nbytes) && $stable(cmd_data));

  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_word));

  // R2
  head_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !cmd_head[7]);

  // R2
  read_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_head[6] |-> cmd_head[5:0] == 6'h3F && cmd_nbytes == 3'd4);

  // R3
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !cmd_valid);
endmodule

bind radio_ctl rc_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_ready   (tx_ready),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_word    (rx_word),
  .cmd_valid  (cmd_valid),
  .cmd_ready  (cmd_ready),
  .cmd_head   (cmd_head),
  .cmd_nbytes (cmd_nbytes),
  .cmd_data   (cmd_data)
);

// File: tb/tb_radio_ctl.sv
`timescale 1ns/1ps
module tb_radio_ctl;
  localparam int CPS    = 4;
  localparam int SETTLE = 12 * CPS;
  localparam logic [42:0] EXP_INIT [0:4] = '{
    {8'h01, 3'd0, 32'h0},
    {8'h11, 3'd2, 32'h0000_02E2},
    {8'h1C, 3'd2, 32'h0000_0040},
    {8'h18, 3'd2, {16'h0, 6'h10, 10'h165}},
    {8'h03, 3'd0, 32'h0}
  };
  localparam logic [31:0] TX_TBL [0:3] = '{
    32'hDEAD_BEEF, 32'h0000_0000, 32'hFFFF_FFFF, 32'h1234_5678
  };

  logic clk = 0;
  logic rst_n = 0;
  logic tx_valid = 0, tx_ready;
  logic [31:0] tx_word = '0;
  logic rx_valid, rx_ready = 1;
  logic [31:0] rx_word;
  logic chan_req = 0;
  logic [9:0] chan_code = 10'h165;
  logic [7:0] bo_mask = 8'h00;
  logic rf_fifo = 0, rf_fifop = 0, rf_cca = 1, rf_sfd = 0;
  logic cmd_valid, cmd_ready;
  logic [7:0] cmd_head;
  logic [2:0] cmd_nbytes;
  logic [31:0] cmd_data;
  logic seq_done;
  logic [31:0] seq_rdata;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 0;

  logic [7:0]  lg_head [0:63];
  logic [2:0]  lg_n    [0:63];
  logic [31:0] lg_data [0:63];
  int          lg_t    [0:63];
  int          lg_cnt = 0;
  int          ms = 0, dly = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  radio_ctl #(.CYC_PER_SYM(CPS)) dut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_word(tx_word), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_word(rx_word),
    .chan_req(chan_req), .chan_code(chan_code), .bo_mask(bo_mask),
    .rf_fifo(rf_fifo), .rf_fifop(rf_fifop), .rf_cca(rf_cca), .rf_sfd(rf_sfd),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_head(cmd_head),
    .cmd_nbytes(cmd_nbytes), .cmd_data(cmd_data), .seq_done(seq_done),
    .seq_rdata(seq_rdata)
  );

  // sequencer model: accepts, logs, completes a few cycles later
  always @(posedge clk) begin
    cmd_ready <= 1'b0;
    seq_done  <= 1'b0;
    if (!rst_n) begin
      ms <= 0;
      seq_rdata <= '0;
    end else begin
      case (ms)
        0: if (cmd_valid) begin cmd_ready <= 1'b1; ms <= 1; end
        1: begin
          if (lg_cnt < 64) begin
            lg_head[lg_cnt] <= cmd_head;
            lg_n[lg_cnt]    <= cmd_nbytes;
            lg_data[lg_cnt] <= cmd_data;
            lg_t[lg_cnt]    <= cyc;
          end
          seq_rdata <= 32'hC0DE_0000 | lg_cnt;
          lg_cnt <= lg_cnt + 1;
          dly <= 1;
          ms <= 2;
        end
        default: if (dly == 0) begin seq_done <= 1'b1; ms <= 0; end
                 else dly <= dly - 1;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_log(input int n, input int lim);
    for (int i = 0; i < lim; i++) begin
      if (lg_cnt >= n) break;
      @(negedge clk);
    end
  endtask

  function automatic int find_head(input int from, input logic [7:0] h);
    for (int i = from; i < lg_cnt && i < 64; i++)
      if (lg_head[i] == h) return i;
    return -1;
  endfunction

  task automatic send_word(input logic [31:0] w);
    for (int i = 0; i < 2000; i++) begin
      if (tx_ready) break;
      @(negedge clk);
    end
    tx_word  = w;
    tx_valid = 1;
    for (int i = 0; i < 2000; i++) begin
      if (tx_ready) break;
      @(negedge clk);
    end
    @(negedge clk);
    tx_valid = 0;
    // R3: ready low right after acceptance
    chk(!tx_ready, "R3 ready after accept", {63'h0, tx_ready}, 64'h0);
  endtask

  task automatic sfd_pulse;
    bit low_ok = 1;
    rf_sfd = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tx_ready) low_ok = 0;
    end
    // R10: ready held low during transmission
    chk(low_ok, "R10 ready while sending", {63'h0, !low_ok}, 64'h0);
    rf_sfd = 0;
    for (int i = 0; i < 10; i++) begin
      if (tx_ready) break;
      @(negedge clk);
    end
    chk(tx_ready, "R10 ready after end of frame", {63'h0, tx_ready}, 64'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base, i04, i7f, t0;
    logic [31:0] w;
    bit hold_ok;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!tx_ready, "R1 reset tx_ready", {63'h0, tx_ready}, 64'h0);
    chk(!cmd_valid, "R1 reset cmd_valid", {63'h0, cmd_valid}, 64'h0);
    chk(!rx_valid, "R1 reset rx_valid", {63'h0, rx_valid}, 64'h0);
    rst_n = 1;

    wait_log(5, 500);
    for (int i = 0; i < 5; i++)
      chk({lg_head[i], lg_n[i], lg_data[i]} == EXP_INIT[i], "R1 init command",
          {21'h0, lg_head[i], lg_n[i], lg_data[i]}, {21'h0, EXP_INIT[i]});
    chk(lg_cnt == 5 && !tx_ready, "R1 ready low in init", {32'h0, lg_cnt}, 64'd5);

    // main vector walk: clear channel
    foreach (TX_TBL[k]) begin
      base = lg_cnt;
      send_word(TX_TBL[k]);
      wait_log(base + 2, 500);
      chk(lg_head[base] == 8'h3E && lg_n[base] == 3'd4 && lg_data[base] == TX_TBL[k],
          "R3 buffer load", {21'h0, lg_head[base], lg_n[base], lg_data[base]},
          {21'h0, 8'h3E, 3'd4, TX_TBL[k]});
      chk(lg_head[base+1] == 8'h04 && lg_n[base+1] == 3'd0, "R4 strobe with clear channel",
          {56'h0, lg_head[base+1]}, 64'h04);
      if (k == 0)
        chk(lg_t[base+1] - lg_t[4] >= SETTLE, "R5 settle after init",
            64'(lg_t[base+1] - lg_t[4]), 64'(SETTLE));
      sfd_pulse();
    end

    // busy channel: backoff, no strobe, receive service
    rf_cca  = 0;
    bo_mask = 8'h03;
    base = lg_cnt;
    send_word(32'h5EED_0001);
    repeat (150) @(negedge clk);
    chk(find_head(base, 8'h04) < 0, "R4 no strobe while busy", 64'(find_head(base, 8'h04)), 64'hFFFF_FFFF_FFFF_FFFF);
    chk(lg_head[base] == 8'h3E && lg_data[base] == 32'h5EED_0001, "R3 load before busy wait",
        {24'h0, lg_head[base], lg_data[base]}, {24'h0, 8'h3E, 32'h5EED_0001});

    rx_ready = 0;
    rf_fifo  = 1;
    rf_fifop = 1;
    i7f = -1;
    for (int i = 0; i < 200; i++) begin
      i7f = find_head(base, 8'h7F);
      if (i7f >= 0) break;
      @(negedge clk);
    end
    rf_fifo  = 0;
    rf_fifop = 0;
    chk(i7f >= 0 && lg_n[i7f] == 3'd4, "R7 read during backoff", 64'(i7f), 64'h0);
    for (int i = 0; i < 50; i++) begin
      if (rx_valid) break;
      @(negedge clk);
    end
    w = rx_word;
    chk(rx_valid && w == (32'hC0DE_0000 | i7f), "R7 received word", {31'h0, rx_valid, w},
        {31'h0, 1'b1, 32'hC0DE_0000 | i7f});
    hold_ok = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!rx_valid || rx_word != w) hold_ok = 0;
    end
    chk(hold_ok, "R7 hold under back-pressure", {32'h0, rx_word}, {32'h0, w});
    rx_ready = 1;
    @(negedge clk);
    @(negedge clk);
    chk(!rx_valid, "R7 word consumed", {63'h0, rx_valid}, 64'h0);

    // R6: release the channel, strobe within masked backoff bound
    rf_cca = 1;
    t0 = cyc;
    i04 = -1;
    for (int i = 0; i < 100; i++) begin
      i04 = find_head(base, 8'h04);
      if (i04 >= 0) break;
      @(negedge clk);
    end
    chk(i04 >= 0 && (lg_t[i04] - t0) <= 4 * CPS + 20, "R6 backoff bound",
        64'(i04 >= 0 ? lg_t[i04] - t0 : -1), 64'(4 * CPS + 20));
    sfd_pulse();

    // R8: overflow flush
    base = lg_cnt;
    rf_fifop = 1;
    rf_fifo  = 0;
    wait_log(base + 1, 100);
    rf_fifop = 0;
    chk(lg_head[base] == 8'h08 && lg_n[base] == 3'd0, "R8 flush strobe",
        {56'h0, lg_head[base]}, 64'h08);

    // R9: run-time channel change
    wait_log(base + 1, 10);
    repeat (10) @(negedge clk);
    base = lg_cnt;
    chan_code = 10'h2A7;
    chan_req  = 1;
    @(negedge clk);
    chan_req  = 0;
    wait_log(base + 3, 300);
    chk(lg_head[base] == 8'h06, "R9 rf off", {56'h0, lg_head[base]}, 64'h06);
    chk(lg_head[base+1] == 8'h18 && lg_n[base+1] == 3'd2 &&
        lg_data[base+1] == {16'h0, 6'h10, 10'h2A7}, "R9 frequency write",
        {21'h0, lg_head[base+1], lg_n[base+1], lg_data[base+1]},
        {21'h0, 8'h18, 3'd2, 16'h0, 6'h10, 10'h2A7});
    chk(lg_head[base+2] == 8'h03, "R9 receive on", {56'h0, lg_head[base+2]}, 64'h03);

    // R5: settle after retune
    send_word(32'hA5A5_0F0F);
    wait_log(base + 5, 500);
    chk(lg_head[base+4] == 8'h04 && lg_t[base+4] - lg_t[base+2] >= SETTLE,
        "R5 settle after retune", 64'(lg_t[base+4] - lg_t[base+2]), 64'(SETTLE));
    sfd_pulse();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule